// File: doc/BRIEF.md
# Memory Stage Stall Controller

This block is the memory stage of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) whose data memory answers after a variable number of cycles. It latches the instruction leaving execute and presents a request, address, store data and write enable to the data memory. If the instruction is a load or a store, the block waits for the memory's ready signal before it lets the instruction go.

While it waits, it raises a freeze signal that holds fetch, decode and execute in place. It also pushes an empty slot (valid bit cleared) into write-back each cycle. When ready arrives, a load's read data is latched into the write-back register at that same clock edge, and the pipeline moves again from the next cycle. Instructions that do not touch memory pass through in a single cycle and never look at ready.

Top module: `mem_stage_ctrl`

## Requirements
- R1: When a valid load (ex_op 2'b01) or store (ex_op 2'b10) sits in the memory stage and mem_ready is 0, freeze is 1 and the instruction stays in the memory stage; the execute-side inputs are ignored for that cycle.
- R2: Each cycle with freeze at 1 also has bubble at 1, and write-back receives an empty slot: after that edge, wb_valid and wb_regwr are 0.
- R3: While a request waits, mem_req, mem_we, mem_addr and mem_wdata keep their values from cycle to cycle.
- R4: In the cycle a pending request sees mem_ready at 1, freeze is 0. At that edge a load's mem_rdata is latched into wb_data with wb_valid at 1, and the memory stage accepts the next instruction.
- R5: mem_we is 1 only while a valid store is in the memory stage; it is 0 for loads, for other operations and for empty slots.
- R6: Operations other than load and store (ex_op 2'b00 or 2'b11) raise no request and ignore mem_ready. They reach write-back one cycle after entering the memory stage, with wb_data equal to their ex_result.
- R7: An empty slot (ex_valid 0) raises neither mem_req nor mem_we and arrives at write-back with wb_valid 0.
- R8: A synchronous reset clears the memory and write-back valid bits and deasserts mem_req, mem_we and freeze, even during a stall.
- R9: A store never sets wb_regwr, even when ex_rwr is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_op | input | 2 | 01 load, 10 store, 00/11 other |
| ex_addr | input | AW | Effective address |
| ex_wdata | input | DW | Store data |
| ex_result | input | DW | Result of a non-memory operation |
| ex_rd | input | RW | Destination register |
| ex_rwr | input | 1 | Instruction writes a register |
| mem_ready | input | 1 | Memory has completed the request |
| mem_rdata | input | DW | Load data from memory |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| freeze | output | 1 | Hold fetch, decode and execute |
| bubble | output | 1 | Empty slot goes to write-back this cycle |
| wb_valid | output | 1 | Write-back slot valid |
| wb_regwr | output | 1 | Write-back writes a register |
| wb_rd | output | RW | Write-back destination register |
| wb_data | output | DW | Write-back data |

## Verification
The hardest situation to reach is a store that enters the memory stage directly behind a load that is still stalled. The store must wait in execute without being lost, and it must start its own wait as soon as the load completes. The stimulus table holds the store at the execute inputs across a multi-cycle load stall, then releases ready for one cycle. It then checks that the store's write enable and address appear in the very next cycle, and that write-back sees the load's data and no register write for the store.

// File: rtl/mem_stage_ctrl.sv
module mem_stage_ctrl #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ex_valid,
  input  logic [1:0]    ex_op,
  input  logic [AW-1:0] ex_addr,
  input  logic [DW-1:0] ex_wdata,
  input  logic [DW-1:0] ex_result,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_rwr,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          freeze,
  output logic          bubble,
  output logic          wb_valid,
  output logic          wb_regwr,
  output logic [RW-1:0] wb_rd,
  output logic [DW-1:0] wb_data
);
  localparam logic [1:0] OP_LOAD  = 2'b01;
  localparam logic [1:0] OP_STORE = 2'b10;

  logic          m_valid, m_load, m_store, m_rwr;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, m_result;
  logic [RW-1:0] m_rd;

  assign mem_req   = m_valid & (m_load | m_store);
  assign mem_we    = m_valid & m_store;
  assign mem_addr  = m_addr;
  assign mem_wdata = m_wdata;
  assign freeze    = mem_req & ~mem_ready;
  assign bubble    = freeze;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid  <= 1'b0;
      m_load   <= 1'b0;
      m_store  <= 1'b0;
      m_rwr    <= 1'b0;
      wb_valid <= 1'b0;
      wb_regwr <= 1'b0;
    end else if (!freeze) begin
      m_valid  <= ex_valid;
      m_load   <= ex_valid & (ex_op == OP_LOAD);
      m_store  <= ex_valid & (ex_op == OP_STORE);
      m_rwr    <= ex_rwr;
      wb_valid <= m_valid;
      wb_regwr <= m_valid & m_rwr & ~m_store;
    end else begin
      wb_valid <= 1'b0;
      wb_regwr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!freeze) begin
      m_addr   <= ex_addr;
      m_wdata  <= ex_wdata;
      m_result <= ex_result;
      m_rd     <= ex_rd;
      wb_rd    <= m_rd;
      wb_data  <= m_load ? mem_rdata : m_result;
    end
  end

  AST_FREEZE_WAITS: assert property (@(posedge clk) disable iff (rst)
    freeze |-> mem_req && !mem_ready); // R1
  AST_BUBBLE_DOWN: assert property (@(posedge clk) disable iff (rst)
    bubble |=> !wb_valid && !wb_regwr); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    freeze |=> mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)); // R3
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready && m_load) |=> wb_valid && wb_data == $past(mem_rdata)); // R4
  AST_WE_IMPLIES_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req); // R5
  AST_STORE_NO_REGWR: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_ready) |=> !wb_regwr); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !mem_req && !wb_valid && !freeze); // R8
endmodule

// File: tb/sim_mem_stage_ctrl.sv
module sim_mem_stage_ctrl;
  logic        clk = 0;
  logic        rst;
  logic        ex_valid;
  logic [1:0]  ex_op;
  logic [31:0] ex_addr, ex_wdata, ex_result, mem_rdata;
  logic [4:0]  ex_rd;
  logic        ex_rwr, mem_ready;
  logic        mem_req, mem_we, freeze, bubble, wb_valid, wb_regwr;
  logic [31:0] mem_addr, mem_wdata, wb_data;
  logic [4:0]  wb_rd;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mem_stage_ctrl u0 (
    .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_op(ex_op), .ex_addr(ex_addr),
    .ex_wdata(ex_wdata), .ex_result(ex_result), .ex_rd(ex_rd), .ex_rwr(ex_rwr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .freeze(freeze), .bubble(bubble),
    .wb_valid(wb_valid), .wb_regwr(wb_regwr), .wb_rd(wb_rd), .wb_data(wb_data)
  );

  typedef struct packed {
    logic       v;
    logic [1:0] op;
    logic [7:0] addr;
    logic [7:0] wd;
    logic [7:0] res;
    logic       rwr;
    logic       rdy;
    logic [7:0] rdata;
    logic       ereq;
    logic       ewe;
    logic       efrz;
    logic [7:0] eaddr;
    logic       ewbv;
    logic       ewbr;
    logic [7:0] ewbd;
  } row_t;

  localparam int NROW = 11;
  localparam row_t TBL [NROW] = '{
    '{1'b1, 2'd0, 8'h00, 8'h00, 8'h11, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00},
    '{1'b1, 2'd1, 8'h40, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h11},
    '{1'b1, 2'd2, 8'h44, 8'hAA, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h40, 1'b0, 1'b0, 8'h00},
    '{1'b1, 2'd2, 8'h44, 8'hAA, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h40, 1'b0, 1'b0, 8'h00},
    '{1'b1, 2'd2, 8'h44, 8'hAA, 8'h00, 1'b1, 1'b1, 8'h5A, 1'b1, 1'b0, 1'b0, 8'h40, 1'b1, 1'b1, 8'h5A},
    '{1'b1, 2'd0, 8'h00, 8'h00, 8'h22, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h44, 1'b0, 1'b0, 8'h00},
    '{1'b1, 2'd0, 8'h00, 8'h00, 8'h22, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 8'h44, 1'b1, 1'b0, 8'h00},
    '{1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h22},
    '{1'b1, 2'd1, 8'h48, 8'h00, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00},
    '{1'b1, 2'd0, 8'h00, 8'h00, 8'h33, 1'b1, 1'b1, 8'h77, 1'b1, 1'b0, 1'b0, 8'h48, 1'b1, 1'b1, 8'h77},
    '{1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h33}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input row_t r);
    ex_valid  = r.v;
    ex_op     = r.op;
    ex_addr   = {24'h0, r.addr};
    ex_wdata  = {24'h0, r.wd};
    ex_result = {24'h0, r.res};
    ex_rd     = 5'd3;
    ex_rwr    = r.rwr;
    mem_ready = r.rdy;
    mem_rdata = {24'h0, r.rdata};
  endtask

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1;
    drive('0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset req", {31'b0, mem_req}, 32'd0);
    chk("R8 reset wb_valid", {31'b0, wb_valid}, 32'd0);
    chk("R8 reset freeze", {31'b0, freeze}, 32'd0);
    rst = 0;

    for (int i = 0; i < NROW; i++) begin
      drive(TBL[i]);
      #1;
      chk("R1/R5/R6/R7 row req", {31'b0, mem_req}, {31'b0, TBL[i].ereq});
      chk("R5 row we", {31'b0, mem_we}, {31'b0, TBL[i].ewe});
      chk("R1 row freeze", {31'b0, freeze}, {31'b0, TBL[i].efrz});
      chk("R2 row bubble", {31'b0, bubble}, {31'b0, TBL[i].efrz});
      if (TBL[i].ereq) chk("R3 row addr", mem_addr, {24'h0, TBL[i].eaddr});
      if (TBL[i].ewe) chk("R3 row wdata", mem_wdata, 32'hAA);
      @(posedge clk);
      #1;
      chk("R2/R4/R7 row wb_valid", {31'b0, wb_valid}, {31'b0, TBL[i].ewbv});
      chk("R9 row wb_regwr", {31'b0, wb_regwr}, {31'b0, TBL[i].ewbr});
      if (TBL[i].ewbr) chk("R4/R6 row wb_data", wb_data, {24'h0, TBL[i].ewbd});
      @(negedge clk);
    end

    // R6: op 2'b11 is a non-memory operation and ignores ready
    drive('{1'b1, 2'd3, 8'h50, 8'h00, 8'h66, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00});
    @(negedge clk);
    ex_valid = 0;
    #1;
    chk("R6 op3 no req", {31'b0, mem_req}, 32'd0);
    chk("R6 op3 no freeze", {31'b0, freeze}, 32'd0);
    @(posedge clk);
    #1;
    chk("R6 op3 wb_data", wb_data, 32'h66);
    chk("R6 op3 wb_valid", {31'b0, wb_valid}, 32'd1);

    // R8: reset during a stall
    @(negedge clk);
    drive('{1'b1, 2'd1, 8'h60, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00});
    @(negedge clk);
    ex_valid = 0;
    #1;
    chk("R1 stall before reset", {31'b0, freeze}, 32'd1);
    rst = 1;
    @(posedge clk);
    #1;
    chk("R8 stall reset req", {31'b0, mem_req}, 32'd0);
    chk("R8 stall reset freeze", {31'b0, freeze}, 32'd0);
    chk("R8 stall reset wb_valid", {31'b0, wb_valid}, 32'd0);
    @(negedge clk);
    rst = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule